// File: doc/BRIEF.md
# Masked Packed Word Left Shifter

This execution unit treats a wide vector operand as a row of 16-bit lanes and moves every lane left by one shared bit count. Zeros enter at the low end of each lane, and nothing carries from one lane into the next. The count comes from one of two places. In immediate mode it is an 8-bit value. In register mode it is the low 64 bits of a 128-bit count vector.

A per-lane write mask then decides, lane by lane, whether the shifted value is written. For a lane that is masked off, the unit writes either the matching lane of a pass-through vector or all zeros, depending on a fill-select input. The vector width is a parameter and may be 128, 256 or 512 bits. The mask has one bit per lane.

Results are registered. A valid/ready pair at the input and another at the output let the unit sit in a stalling pipeline. Lane `i` occupies bits `16*i+15 : 16*i` of every vector port, and mask bit `i` governs lane `i`.

Top module: `wshl_unit`

## Requirements
- R1: Every 16-bit lane of `src_a` is shifted left by the same effective count, and zeros fill the vacated low bits of each lane; no bit crosses a lane boundary.
- R2: When `cnt_from_reg` is 0, the count is `imm_cnt`, and `cnt_vec` has no effect on the result.
- R3: When `cnt_from_reg` is 1, the count is `cnt_vec[63:0]`; bits `cnt_vec[127:64]` and `imm_cnt` have no effect on the result.
- R4: A count above 15, judged over all 8 bits of `imm_cnt` or all 64 low bits of `cnt_vec`, makes every shifted lane 16'h0000; the count is never reduced modulo 16.
- R5: When `mask_en` is 0, every lane takes its shifted value whatever `lane_mask` holds. When `mask_en` is 1, lane `i` takes its shifted value exactly when `lane_mask[i]` is 1.
- R6: With `mask_en` 1 and `zero_fill` 0, a lane whose mask bit is 0 takes the matching lane of `pass_vec`.
- R7: With `mask_en` 1 and `zero_fill` 1, a lane whose mask bit is 0 is written as 16'h0000.
- R8: `in_ready` is high when the output register is empty or is being drained (`out_ready` high). A transfer accepted at a clock edge sets `out_valid`, and the result is on `out_data` after that same edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value, and no new input is accepted.
- R10: After reset, `out_valid` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Unit can accept a transfer |
| cnt_from_reg | input | 1 | 0: count from `imm_cnt`; 1: count from `cnt_vec[63:0]` |
| zero_fill | input | 1 | 0: masked-off lanes merge from `pass_vec`; 1: they become zero |
| mask_en | input | 1 | Enables per-lane masking |
| imm_cnt | input | 8 | Immediate shift count |
| cnt_vec | input | 128 | Count operand; only the low 64 bits are used |
| src_a | input | VW | Vector to be shifted |
| pass_vec | input | VW | Merge source for masked-off lanes |
| lane_mask | input | VW/16 | One mask bit per lane |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VW | Registered result vector |

## Verification
The lane assertions read the operand and control ports one cycle back and compare them with the registered output. They therefore rely on the inputs being stable across the accepting edge. The bench drives every input on the falling clock edge and changes nothing until the next falling edge. The stall assertion relies on the consumer keeping `out_ready` at a steady level for the whole cycle. The bench sets it only at falling edges, and while a stall is held it keeps offering a second transfer so that a wrongly accepted input would show up in the output.

// File: rtl/wshl_unit.sv
module wshl_unit #(
  parameter int VW = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                cnt_from_reg,
  input  logic                zero_fill,
  input  logic                mask_en,
  input  logic [7:0]          imm_cnt,
  input  logic [127:0]        cnt_vec,
  input  logic [VW-1:0]       src_a,
  input  logic [VW-1:0]       pass_vec,
  input  logic [VW/16-1:0]    lane_mask,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VW-1:0]       out_data
);
  localparam int LW    = 16;
  localparam int LANES = VW / LW;
  localparam int AW    = $clog2(LW);

  logic          take;
  logic          too_far;
  logic [AW-1:0] amt;
  logic [VW-1:0] nxt;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  assign too_far = cnt_from_reg ? (|cnt_vec[63:AW]) : (|imm_cnt[7:AW]);
  assign amt     = cnt_from_reg ? cnt_vec[AW-1:0] : imm_cnt[AW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] shl, alt;
    logic          keep;
    assign shl  = too_far ? '0 : (src_a[l*LW +: LW] << amt);
    assign keep = !mask_en || lane_mask[l];
    assign alt  = zero_fill ? '0 : pass_vec[l*LW +: LW];
    assign nxt[l*LW +: LW] = keep ? shl : alt;

    a_r6_merge_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mask_en && !zero_fill && !lane_mask[l])
      |=> out_data[l*LW +: LW] == $past(pass_vec[l*LW +: LW]));

    a_r7_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mask_en && zero_fill && !lane_mask[l])
      |=> out_data[l*LW +: LW] == '0);

    a_r4_big_count: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (!mask_en || lane_mask[l]) &&
       (cnt_from_reg ? (|cnt_vec[63:AW]) : (|imm_cnt[7:AW])))
      |=> out_data[l*LW +: LW] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_accept_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r1_zero_count_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mask_en && !cnt_from_reg && imm_cnt == 8'd0)
    |=> out_data == $past(src_a));

  a_r5_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mask_en && !cnt_from_reg && imm_cnt == 8'd1)
    |=> ($countones(out_data & {LANES{16'h0001}}) == 0));
endmodule

// File: tb/wshl_unit_bench.sv
module wshl_unit_bench;
  localparam int VW = 128;
  localparam int LN = VW / 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, cnt_from_reg = 0, zero_fill = 0, mask_en = 0, out_ready = 1;
  logic [7:0] imm_cnt = 0;
  logic [127:0] cnt_vec = 0;
  logic [VW-1:0] src_a = 0, pass_vec = 0;
  logic [LN-1:0] lane_mask = 0;
  logic in_ready, out_valid;
  logic [VW-1:0] out_data;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  wshl_unit #(.VW(VW)) u_wshl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cnt_from_reg(cnt_from_reg), .zero_fill(zero_fill), .mask_en(mask_en),
    .imm_cnt(imm_cnt), .cnt_vec(cnt_vec), .src_a(src_a), .pass_vec(pass_vec),
    .lane_mask(lane_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  function automatic logic [VW-1:0] expect_vec(input logic reg_m, input logic zf,
      input logic me, input logic [7:0] im, input logic [127:0] cv,
      input logic [VW-1:0] a, input logic [VW-1:0] p, input logic [LN-1:0] m);
    logic [VW-1:0] r;
    logic [63:0] c;
    c = reg_m ? cv[63:0] : {56'd0, im};
    for (int l = 0; l < LN; l++) begin
      logic [15:0] s;
      s = 16'd0;
      for (int b = 0; b < 16; b++)
        if (c <= 64'd15 && b >= int'(c)) s[b] = a[l*16 + b - int'(c)];
      if (!me || m[l]) r[l*16 +: 16] = s;
      else r[l*16 +: 16] = zf ? 16'd0 : p[l*16 +: 16];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic reg_m, input logic zf, input logic me,
      input logic [7:0] im, input logic [127:0] cv, input logic [VW-1:0] a,
      input logic [VW-1:0] p, input logic [LN-1:0] m);
    @(negedge clk);
    cnt_from_reg = reg_m; zero_fill = zf; mask_en = me; imm_cnt = im;
    cnt_vec = cv; src_a = a; pass_vec = p; lane_mask = m;
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
    check(req, out_data, expect_vec(reg_m, zf, me, im, cv, a, p, m));
  endtask

  logic [VW-1:0] pat_a, pat_b;

  task automatic t_reset;
    check("R10 out_valid", {{(VW-1){1'b0}}, out_valid}, '0);
    check("R10 out_data", out_data, '0);
  endtask

  task automatic t_imm_shifts;
    run_op("R1 R2 imm 0", 0, 0, 0, 8'd0, '1, pat_a, '0, '0);
    run_op("R1 R2 imm 1", 0, 0, 0, 8'd1, '1, pat_a, '0, '0);
    run_op("R1 R2 imm 7", 0, 0, 0, 8'd7, 128'd2, pat_b, '0, '0);
    run_op("R1 R2 imm 15", 0, 0, 0, 8'd15, '0, pat_a, '0, '0);
    check("R1 imm 15 vs pattern", out_data, {LN{16'h8000}} & {pat_a[112],15'd0,pat_a[96],15'd0,
      pat_a[80],15'd0,pat_a[64],15'd0,pat_a[48],15'd0,pat_a[32],15'd0,pat_a[16],15'd0,pat_a[0],15'd0});
  endtask

  task automatic t_big_counts;
    run_op("R4 imm 16", 0, 0, 0, 8'd16, '0, pat_a, '0, '0);
    check("R4 imm 16 zero", out_data, '0);
    run_op("R4 imm 255", 0, 0, 0, 8'd255, '0, pat_b, '0, '0);
    check("R4 imm 255 zero", out_data, '0);
    run_op("R4 reg bit40", 1, 0, 0, 8'd0, {64'd0, 64'h0000_0100_0000_0002}, pat_a, '0, '0);
    check("R4 reg bit40 zero", out_data, '0);
  endtask

  task automatic t_reg_count;
    run_op("R3 reg 3 upper junk", 1, 0, 0, 8'd200, {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, pat_a, '0, '0);
    run_op("R3 reg 12 imm ignored", 1, 0, 0, 8'd1, {64'h1234, 64'd12}, pat_b, '0, '0);
    run_op("R2 imm 5 cnt_vec ignored", 0, 0, 0, 8'd5, {64'd0, 64'hFFFF}, pat_b, '0, '0);
  endtask

  task automatic t_masks;
    run_op("R5 R6 merge", 0, 0, 1, 8'd4, '0, pat_a, pat_b, 8'b1010_0110);
    check("R6 lane0 merged", {112'd0, out_data[15:0]}, {112'd0, pat_b[15:0]});
    run_op("R5 R7 zeroing", 1, 1, 1, 8'd0, {64'd0, 64'd2}, pat_b, pat_a, 8'b0011_1001);
    check("R7 lane1 zero", {112'd0, out_data[31:16]}, '0);
    run_op("R5 mask off ignores mask", 0, 1, 0, 8'd3, '0, pat_a, pat_b, 8'h00);
    run_op("R6 all merged", 0, 0, 1, 8'd9, '0, pat_a, pat_b, 8'h00);
    check("R6 all merged eq", out_data, pat_b);
  endtask

  task automatic t_stall;
    logic [VW-1:0] held;
    @(negedge clk);
    cnt_from_reg = 0; zero_fill = 0; mask_en = 0; imm_cnt = 8'd2;
    src_a = pat_a; in_valid = 1; out_ready = 0;
    @(negedge clk);
    held = expect_vec(0, 0, 0, 8'd2, '0, pat_a, '0, '0);
    check("R8 accepted", out_data, held);
    check("R8 in_ready low when full", {{(VW-1){1'b0}}, in_ready}, '0);
    imm_cnt = 8'd6; src_a = pat_b;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 hold data", out_data, held);
      check("R9 hold valid", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
    end
    out_ready = 1;
    #1 check("R8 in_ready on drain", {{(VW-1){1'b0}}, in_ready}, {{(VW-1){1'b0}}, 1'b1});
    @(negedge clk);
    in_valid = 0;
    check("R8 second result", out_data, expect_vec(0, 0, 0, 8'd6, '0, pat_b, '0, '0));
    @(negedge clk);
    check("R8 drained", {{(VW-1){1'b0}}, out_valid}, '0);
  endtask

  initial begin
    for (int l = 0; l < LN; l++) begin
      pat_a[l*16 +: 16] = 16'h8001 ^ (16'h1357 * 16'(l + 1));
      pat_b[l*16 +: 16] = 16'hF0F0 ^ (16'h0F11 * 16'(l));
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_imm_shifts;
    t_big_counts;
    t_reg_count;
    t_masks;
    t_stall;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule